// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block is a passive observer that sits on the command side of a four-bank SDRAM bus. On every clock it decodes the command pins into one command. It keeps, for each bank, an idle, open or auto-closing state, along with countdown timers for each minimum gap. Whenever a command breaks a state rule or arrives too early, the monitor reports it. It never drives the bus, and it looks at no data or mask pins.

Every violation produces a one-cycle pulse in the clock after the offending command. The first violation after reset is also captured as a sticky flag, together with a violation code and the bank it concerns, and these stay until the next reset. All minimum gaps are parameters counted in clocks. A gap of N means that the later command is legal N or more clocks after the earlier one.

The monitor follows the bus even when a command is illegal: a flagged command still changes the tracked state. The monitor does not model self refresh, power-down or data.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when `cke` is high both in this clock and in the previous clock, and `cs_n` is low. The pattern {ras_n,cas_n,we_n} gives the command: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no-operation. Every other cycle is a no-operation.
- R2: A mode set or refresh while any bank is not idle is violation code 2. The reported bank is the lowest-numbered bank that is not idle.
- R3: Any command other than a no-operation issued fewer than T_MRD clocks after a mode set is code 1, reported against `ba`.
- R4: A precharge with `a10` high closes every open bank, whatever `ba` holds. Without `a10`, it closes only bank `ba`.
- R5: A read or write fewer than T_RCD clocks after the activate of its bank is code 6.
- R6: An activate fewer than T_RP clocks after its bank closed is code 7. An activate fewer than T_RRD clocks after an activate to a different bank is code 8.
- R7: A precharge of an open bank fewer than T_RAS clocks after its activate is code 9. A precharge fewer than BURST_LEN-1+T_WR clocks after a write to that bank is code 10.
- R8: A read or write with `a10` high to an open bank starts an auto-closing burst of BURST_LEN clocks. Any read or write during that burst is code 3. The bank closes BURST_LEN clocks after the command, so an activate to it is legal from BURST_LEN+T_RP clocks on.
- R9: A read or write to a bank that is not open (idle or auto-closing) is code 4. An activate to a bank that is not idle is code 5.
- R10: When several rules fail, the code reported is the first in this order: 1, 2 or 5 (state), 3, 4, 6, 7, 8, 9, 10. Within one bank, a precharge reports 9 before 10. An all-bank precharge reports the lowest-numbered failing bank.
- R11: `err_pulse` is high in the clock after each violating command. `err_valid`, `err_code` and `err_bank` capture the first violation and hold it until reset.
- R12: After reset all outputs are zero and every bank is idle with no timer running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank / auto-close select) |
| err_pulse | output | 1 | One-cycle pulse per violation |
| err_valid | output | 1 | Sticky: a violation has been seen |
| err_code | output | 4 | Code of the first violation |
| err_bank | output | BA_W (2) | Bank of the first violation |

## Verification
A bank whose state or timer is wrong shows up only when a later command reaches it. In the clock after that command, a pulse either appears where none should or is missing, or it carries the wrong code. For example, a bank wrongly left open turns a later refresh into code 2. A timer that is one count off moves the pass/fail boundary by one clock, so each gap is exercised both on its exact limit and one clock short of it. An auto-closing bank that closes late shows up either as code 5 on the first legal activate or as a missed code 7.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MODE, CMD_REFR, CMD_ACT, CMD_READ, CMD_WRITE, CMD_PRE, CMD_STOP
  } cmd_e;

  typedef enum logic [3:0] {
    VIOL_NONE       = 4'd0,
    VIOL_MODE_GAP   = 4'd1,
    VIOL_NOT_IDLE   = 4'd2,
    VIOL_COL_BUSY   = 4'd3,
    VIOL_COL_CLOSED = 4'd4,
    VIOL_ACT_OPEN   = 4'd5,
    VIOL_RCD        = 4'd6,
    VIOL_RP         = 4'd7,
    VIOL_RRD        = 4'd8,
    VIOL_RAS        = 4'd9,
    VIOL_WREC       = 4'd10
  } viol_e;

  typedef enum logic [1:0] {BK_IDLE, BK_OPEN, BK_AUTOCLOSE} bank_st_e;

  typedef struct packed {
    bank_st_e st;
    logic     rcd_busy;
    logic     rp_busy;
    logic     ras_busy;
    logic     wr_busy;
    logic     col_busy;
  } bank_view_t;

  function automatic int unsigned gmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic live,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  // R1: pin pattern to command, gated by clock enable history and select
  always_comb begin
    cmd = CMD_NOP;
    if (live && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MODE;
        3'b001:  cmd = CMD_REFR;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = CMD_PRE;
        3'b110:  cmd = CMD_STOP;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned CW        = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic       hit,
  input  logic       a10,
  output bank_view_t view
);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_WR  = CW'(BURST_LEN + T_WR - 2);
  localparam logic [CW-1:0] LD_AP  = CW'(BURST_LEN - 1);

  bank_st_e st_q, st_d;
  logic [CW-1:0] rcd_q, rcd_d, rp_q, rp_d, ras_q, ras_d, wr_q, wr_d, ap_q, ap_d;

  function automatic logic [CW-1:0] down(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  always_comb begin
    st_d  = st_q;
    rcd_d = down(rcd_q);
    rp_d  = down(rp_q);
    ras_d = down(ras_q);
    wr_d  = down(wr_q);
    ap_d  = down(ap_q);
    // R8: auto-closing burst ends, bank closes, row precharge time starts
    if (st_q == BK_AUTOCLOSE && ap_q == '0) begin
      st_d = BK_IDLE;
      rp_d = LD_RP;
    end
    case (cmd)
      CMD_ACT: if (hit) begin
        st_d  = BK_OPEN;
        rcd_d = LD_RCD;
        ras_d = LD_RAS;
      end
      CMD_PRE: if ((hit || a10) && st_q == BK_OPEN) begin
        st_d = BK_IDLE;
        rp_d = LD_RP;
      end
      CMD_READ, CMD_WRITE: if (hit) begin
        if (cmd == CMD_WRITE) wr_d = LD_WR;
        if (a10 && st_q == BK_OPEN) begin
          st_d = BK_AUTOCLOSE;
          ap_d = LD_AP;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      rcd_q <= '0;
      rp_q  <= '0;
      ras_q <= '0;
      wr_q  <= '0;
      ap_q  <= '0;
    end else begin
      st_q  <= st_d;
      rcd_q <= rcd_d;
      rp_q  <= rp_d;
      ras_q <= ras_d;
      wr_q  <= wr_d;
      ap_q  <= ap_d;
    end
  end

  assign view.st       = st_q;
  assign view.rcd_busy = (rcd_q != '0);
  assign view.rp_busy  = (rp_q != '0);
  assign view.ras_busy = (ras_q != '0);
  assign view.wr_busy  = (wr_q != '0);
  assign view.col_busy = (st_q == BK_AUTOCLOSE) && (ap_q != '0);

  // R4
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && a10 && st_q == BK_OPEN) |=> (st_q == BK_IDLE));

  // R8
  autoclose_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_AUTOCLOSE && ap_q == '0 && !(cmd == CMD_ACT && hit)) |=> (st_q == BK_IDLE));

  // R9
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && hit) |=> (st_q == BK_OPEN));
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 2
) (
  input  cmd_e                  cmd,
  input  logic [BW-1:0]         ba,
  input  logic                  a10,
  input  bank_view_t [NB-1:0]   views,
  input  logic                  mode_busy,
  input  logic                  rrd_busy,
  input  logic [BW-1:0]         rrd_bank,
  output viol_e                 code,
  output logic [BW-1:0]         bank
);
  logic          any_col_busy;
  logic          any_active;
  logic [BW-1:0] first_active;

  always_comb begin
    any_col_busy = 1'b0;
    any_active   = 1'b0;
    first_active = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (views[i].col_busy) any_col_busy = 1'b1;
      if (views[i].st != BK_IDLE) begin
        any_active   = 1'b1;
        first_active = BW'(i);
      end
    end
  end

  // R10: fixed priority among the rules
  always_comb begin
    code = VIOL_NONE;
    bank = ba;
    if (cmd != CMD_NOP && mode_busy) begin
      code = VIOL_MODE_GAP;
    end else begin
      case (cmd)
        CMD_MODE, CMD_REFR: if (any_active) begin
          code = VIOL_NOT_IDLE;
          bank = first_active;
        end
        CMD_ACT: begin
          if (views[ba].st != BK_IDLE)        code = VIOL_ACT_OPEN;
          else if (views[ba].rp_busy)         code = VIOL_RP;
          else if (rrd_busy && rrd_bank != ba) code = VIOL_RRD;
        end
        CMD_READ, CMD_WRITE: begin
          if (any_col_busy)                   code = VIOL_COL_BUSY;
          else if (views[ba].st != BK_OPEN)   code = VIOL_COL_CLOSED;
          else if (views[ba].rcd_busy)        code = VIOL_RCD;
        end
        CMD_PRE: begin
          for (int i = NB - 1; i >= 0; i--) begin
            if ((a10 || ba == BW'(i)) && views[i].st == BK_OPEN &&
                (views[i].ras_busy || views[i].wr_busy)) begin
              code = views[i].ras_busy ? VIOL_RAS : VIOL_WREC;
              bank = BW'(i);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            err_pulse,
  output logic            err_valid,
  output logic [3:0]      err_code,
  output logic [BA_W-1:0] err_bank
);
  localparam int unsigned NB   = 1 << BA_W;
  localparam int unsigned MAXG = gmax(gmax(gmax(T_RCD, T_RP), gmax(T_RAS, T_MRD)),
                                      gmax(T_RRD, BURST_LEN + T_WR));
  localparam int unsigned CW   = $clog2(MAXG + 1);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 1);
  localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);

  logic                cke_q, live;
  cmd_e                cmd;
  logic [CW-1:0]       mode_q, mode_d, rrd_q, rrd_d;
  logic [BA_W-1:0]     rrdb_q, rrdb_d;
  bank_view_t [NB-1:0] views;
  viol_e               chk_code;
  logic [BA_W-1:0]     chk_bank;
  logic                pulse_d, valid_d;
  logic [3:0]          code_d;
  logic [BA_W-1:0]     bank_d;

  assign live = cke & cke_q;

  sdram_cmd_decode u_decode (
    .live(live), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_track #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR),
      .BURST_LEN(BURST_LEN), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(ba == BA_W'(g)), .a10(a10),
      .view(views[g])
    );
  end

  sdram_rule_check #(.NB(NB), .BW(BA_W)) u_rules (
    .cmd(cmd), .ba(ba), .a10(a10), .views(views),
    .mode_busy(mode_q != '0), .rrd_busy(rrd_q != '0), .rrd_bank(rrdb_q),
    .code(chk_code), .bank(chk_bank)
  );

  always_comb begin
    mode_d = (mode_q == '0) ? mode_q : mode_q - CW'(1);
    rrd_d  = (rrd_q == '0) ? rrd_q : rrd_q - CW'(1);
    rrdb_d = rrdb_q;
    if (cmd == CMD_MODE) mode_d = LD_MRD;
    if (cmd == CMD_ACT) begin
      rrd_d  = LD_RRD;
      rrdb_d = ba;
    end
    // R11: pulse per violation, first one captured
    pulse_d = (chk_code != VIOL_NONE);
    valid_d = err_valid;
    code_d  = err_code;
    bank_d  = err_bank;
    if (pulse_d && !err_valid) begin
      valid_d = 1'b1;
      code_d  = chk_code;
      bank_d  = chk_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      mode_q    <= '0;
      rrd_q     <= '0;
      rrdb_q    <= '0;
      err_pulse <= 1'b0;
      err_valid <= 1'b0;
      err_code  <= '0;
      err_bank  <= '0;
    end else begin
      cke_q     <= cke;
      mode_q    <= mode_d;
      rrd_q     <= rrd_d;
      rrdb_q    <= rrdb_d;
      err_pulse <= pulse_d;
      err_valid <= valid_d;
      err_code  <= code_d;
      err_bank  <= bank_d;
    end
  end

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (err_valid && $stable(err_code) && $stable(err_bank)));

  // R11
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_valid);

  if (T_MRD > 1) begin : g_mrd_chk
    // R3
    mode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd) == CMD_MODE && cmd != CMD_NOP) |=> err_pulse);
  end
endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  localparam int T_RCD = 3, T_RP = 3, T_RRD = 2, T_RAS = 6, T_WR = 2, T_MRD = 2, BL = 4;
  localparam int NB = 4;
  localparam int K_NOP = 0, K_MODE = 1, K_REF = 2, K_ACT = 3, K_RD = 4, K_WR = 5, K_PRE = 6, K_BST = 7;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic err_pulse, err_valid;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  always #2 clk = ~clk;

  sdram_cmd_monitor #(
    .BA_W(2), .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RAS(T_RAS),
    .T_WR(T_WR), .T_MRD(T_MRD), .BURST_LEN(BL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_pulse(err_pulse), .err_valid(err_valid),
    .err_code(err_code), .err_bank(err_bank)
  );

  int checks = 0, fails = 0;

  // behavioural reference: timestamps per bank
  int  now, mode_t, act_any_t, act_any_b;
  int  act_t[NB], close_t[NB], wr_t[NB], ap_t[NB];
  bit  opn[NB], apc[NB];
  bit  prev_cke;
  bit  e_pulse, e_valid;
  int  e_code, e_bank;

  function automatic logic [2:0] rcw_of(input int k);
    case (k)
      K_MODE: return 3'b000;
      K_REF:  return 3'b001;
      K_ACT:  return 3'b011;
      K_RD:   return 3'b101;
      K_WR:   return 3'b100;
      K_PRE:  return 3'b010;
      K_BST:  return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int kind_of(input logic [2:0] rcw);
    case (rcw)
      3'b000: return K_MODE;
      3'b001: return K_REF;
      3'b011: return K_ACT;
      3'b101: return K_RD;
      3'b100: return K_WR;
      3'b010: return K_PRE;
      3'b110: return K_BST;
      default: return K_NOP;
    endcase
  endfunction

  task automatic model_reset();
    now = 0; mode_t = -1000; act_any_t = -1000; act_any_b = 0; prev_cke = 0;
    for (int i = 0; i < NB; i++) begin
      act_t[i] = -1000; close_t[i] = -1000; wr_t[i] = -1000; ap_t[i] = -1000;
      opn[i] = 0; apc[i] = 0;
    end
    e_pulse = 0; e_valid = 0; e_code = 0; e_bank = 0;
  endtask

  task automatic model_step(input bit cke_v, input bit cs_v, input logic [2:0] rcw,
                            input int b, input bit ap);
    int k, code, bnk;
    bit busy, found;
    k = (cke_v && prev_cke && !cs_v) ? kind_of(rcw) : K_NOP;
    prev_cke = cke_v;
    for (int i = 0; i < NB; i++)
      if (apc[i] && now > ap_t[i] + BL) begin
        apc[i] = 0; opn[i] = 0; close_t[i] = ap_t[i] + BL;
      end
    code = 0; bnk = b;
    if (k != K_NOP && now - mode_t < T_MRD) code = 1;
    else if (k == K_MODE || k == K_REF) begin
      found = 0;
      for (int i = 0; i < NB; i++)
        if (!found && opn[i]) begin found = 1; code = 2; bnk = i; end
    end else if (k == K_ACT) begin
      if (opn[b]) code = 5;
      else if (now - close_t[b] < T_RP) code = 7;
      else if (act_any_b != b && now - act_any_t < T_RRD) code = 8;
    end else if (k == K_RD || k == K_WR) begin
      busy = 0;
      for (int i = 0; i < NB; i++) if (apc[i] && now - ap_t[i] < BL) busy = 1;
      if (busy) code = 3;
      else if (!opn[b] || apc[b]) code = 4;
      else if (now - act_t[b] < T_RCD) code = 6;
    end else if (k == K_PRE) begin
      found = 0;
      for (int i = 0; i < NB; i++)
        if (!found && (ap || i == b) && opn[i] && !apc[i]) begin
          if (now - act_t[i] < T_RAS) begin found = 1; code = 9; bnk = i; end
          else if (now - wr_t[i] < BL - 1 + T_WR) begin found = 1; code = 10; bnk = i; end
        end
    end
    e_pulse = (code != 0);
    if (e_pulse && !e_valid) begin e_valid = 1; e_code = code; e_bank = bnk; end
    case (k)
      K_MODE: mode_t = now;
      K_ACT: begin
        opn[b] = 1; apc[b] = 0; act_t[b] = now; act_any_t = now; act_any_b = b;
      end
      K_RD, K_WR: begin
        if (k == K_WR) wr_t[b] = now;
        if (opn[b] && !apc[b] && ap) begin apc[b] = 1; ap_t[b] = now; end
      end
      K_PRE:
        for (int i = 0; i < NB; i++)
          if ((ap || i == b) && opn[i] && !apc[i]) begin opn[i] = 0; close_t[i] = now; end
      default: ;
    endcase
    now++;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (err_pulse !== e_pulse || err_valid !== e_valid ||
        err_code !== 4'(e_code) || err_bank !== 2'(e_bank)) begin
      fails++;
      $display("FAIL %s: actual pulse=%0b valid=%0b code=%0d bank=%0d, expected pulse=%0b valid=%0b code=%0d bank=%0d",
               tag, err_pulse, err_valid, err_code, err_bank, e_pulse, e_valid, e_code, e_bank);
    end
  endtask

  task automatic drive(input bit cke_v, input bit cs_v, input logic [2:0] rcw,
                       input int b, input bit ap, input string tag);
    cke = cke_v; cs_n = cs_v; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); a10 = ap;
    model_step(cke_v, cs_v, rcw, b, ap);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic issue(input int k, input int b, input bit ap, input string tag);
    drive(1'b1, 1'b0, rcw_of(k), b, ap, tag);
  endtask

  task automatic idle(input int n, input string tag);
    repeat (n) issue(K_NOP, 0, 0, tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = 0; a10 = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    compare(tag);
    issue(K_NOP, 0, 0, tag);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    report();
  end

  initial begin
    @(negedge clk);
    do_reset("R12");
    // R1: deselected and clock-disabled cycles decode nothing
    drive(1'b1, 1'b1, rcw_of(K_ACT), 0, 0, "R1");
    drive(1'b0, 1'b0, rcw_of(K_ACT), 0, 0, "R1");
    drive(1'b1, 1'b0, rcw_of(K_ACT), 0, 0, "R1");
    issue(K_RD, 0, 0, "R1");
    do_reset("R12");
    issue(K_ACT, 0, 0, "R1"); idle(2, "R1"); issue(K_RD, 0, 0, "R1"); issue(K_WR, 0, 0, "R1");
    issue(K_BST, 0, 0, "R1");
    // R3: mode gap
    do_reset("R12");
    issue(K_MODE, 0, 0, "R3"); issue(K_ACT, 1, 0, "R3"); idle(1, "R3");
    do_reset("R12");
    issue(K_MODE, 0, 0, "R3"); idle(1, "R3"); issue(K_ACT, 1, 0, "R3");
    // R2: refresh with a bank open
    do_reset("R12");
    issue(K_ACT, 1, 0, "R2"); idle(3, "R2"); issue(K_REF, 0, 0, "R2");
    // R5: activate to column gap
    do_reset("R12");
    issue(K_ACT, 2, 0, "R5"); issue(K_RD, 2, 0, "R5");
    do_reset("R12");
    issue(K_ACT, 2, 0, "R5"); idle(1, "R5"); issue(K_WR, 2, 0, "R5");
    // R6: precharge time and activate-to-activate gap
    do_reset("R12");
    issue(K_ACT, 0, 0, "R6"); idle(5, "R6"); issue(K_PRE, 0, 0, "R6"); issue(K_ACT, 0, 0, "R6");
    do_reset("R12");
    issue(K_ACT, 0, 0, "R6"); idle(5, "R6"); issue(K_PRE, 0, 0, "R6"); idle(2, "R6");
    issue(K_ACT, 0, 0, "R6");
    do_reset("R12");
    issue(K_ACT, 0, 0, "R6"); issue(K_ACT, 1, 0, "R6");
    do_reset("R12");
    issue(K_ACT, 0, 0, "R6"); idle(1, "R6"); issue(K_ACT, 1, 0, "R6");
    // R7: row active time and write recovery
    do_reset("R12");
    issue(K_ACT, 3, 0, "R7"); idle(1, "R7"); issue(K_PRE, 3, 0, "R7");
    do_reset("R12");
    issue(K_ACT, 3, 0, "R7"); idle(5, "R7"); issue(K_WR, 3, 0, "R7"); issue(K_PRE, 3, 0, "R7");
    do_reset("R12");
    issue(K_ACT, 3, 0, "R7"); idle(5, "R7"); issue(K_WR, 3, 0, "R7"); idle(4, "R7");
    issue(K_PRE, 3, 0, "R7");
    do_reset("R12");
    issue(K_ACT, 3, 0, "R7"); idle(5, "R7"); issue(K_WR, 3, 0, "R7"); idle(3, "R7");
    issue(K_PRE, 3, 0, "R7");
    // R8: auto-closing bursts
    do_reset("R12");
    issue(K_ACT, 0, 0, "R8"); idle(1, "R8"); issue(K_ACT, 1, 0, "R8"); idle(1, "R8");
    issue(K_RD, 0, 1, "R8"); issue(K_RD, 1, 0, "R8");
    do_reset("R12");
    issue(K_ACT, 0, 0, "R8"); idle(2, "R8"); issue(K_WR, 0, 1, "R8"); idle(5, "R8");
    issue(K_ACT, 0, 0, "R8");
    do_reset("R12");
    issue(K_ACT, 0, 0, "R8"); idle(2, "R8"); issue(K_WR, 0, 1, "R8"); idle(6, "R8");
    issue(K_ACT, 0, 0, "R8"); idle(2, "R8"); issue(K_RD, 0, 0, "R8");
    do_reset("R12");
    issue(K_ACT, 1, 0, "R8"); idle(2, "R8"); issue(K_RD, 1, 1, "R8"); idle(3, "R8");
    issue(K_RD, 1, 0, "R8");
    // R9: state errors
    do_reset("R12");
    issue(K_RD, 1, 0, "R9");
    do_reset("R12");
    issue(K_ACT, 2, 0, "R9"); issue(K_ACT, 2, 0, "R9");
    // R4: precharge-all closes every bank regardless of BA
    do_reset("R12");
    issue(K_ACT, 0, 0, "R4"); idle(1, "R4"); issue(K_ACT, 1, 0, "R4"); idle(6, "R4");
    issue(K_PRE, 3, 1, "R4"); idle(3, "R4"); issue(K_REF, 0, 0, "R4"); issue(K_ACT, 0, 0, "R4");
    // R10: lowest failing bank, priority of mode gap
    do_reset("R12");
    issue(K_ACT, 0, 0, "R10"); idle(5, "R10"); issue(K_ACT, 2, 0, "R10"); issue(K_PRE, 1, 1, "R10");
    do_reset("R12");
    issue(K_ACT, 1, 0, "R10"); idle(5, "R10"); issue(K_WR, 1, 0, "R10"); idle(1, "R10");
    issue(K_ACT, 3, 0, "R10"); issue(K_PRE, 0, 1, "R10");
    do_reset("R12");
    issue(K_MODE, 0, 0, "R10"); issue(K_REF, 2, 0, "R10");
    // R11: pulse per violation, first one sticky
    do_reset("R12");
    issue(K_ACT, 0, 0, "R11"); issue(K_RD, 1, 0, "R11"); issue(K_RD, 0, 0, "R11");
    idle(2, "R11"); issue(K_ACT, 0, 0, "R11"); idle(2, "R11");
    do_reset("R12");
    idle(2, "R12");
    report();
  end
endmodule